// File: doc/BRIEF.md
# Pulse-and-verify byte programming sequencer

This controller writes a range of bytes into a flash array that has no internal program automation. For each byte it issues timed program pulses over a simple flash bus. After every pulse it sends a verify command, waits, reads the byte back and compares it with the expected value, which comes from a source buffer indexed by the current address. A byte that still reads wrong after the pulse budget is spent ends the run with an error that names the failing address.

Around the whole range the sequencer asks a regulator for the high programming voltage. It waits a fixed ramp time before the first command, and again after it drops the request. On success it leaves the array in read mode. Every delay is a parameter counted in clock cycles.

Top module: `qp_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `err_o`, `vpp_req_o`, `flash_we_o` and `flash_oe_o` are all low.
- R2: `start_i` is accepted only while idle. A start pulse during a run has no effect on the range programmed or on the number of completions.
- R3: On an accepted start, `vpp_req_o` rises. The first flash write comes exactly `RAMP_CYC` cycles after the first cycle in which `vpp_req_o` is high. Flash writes occur only while `vpp_req_o` is high.
- R4: Each pulse is a write of data 40h, then in the next cycle a write of the buffer byte to the current address. The verify command (data C0h) is written `PGM_CYC + 1` cycles after that data write.
- R5: A single read strobe cycle (`flash_oe_o`) follows `VFY_CYC + 1` cycles after the verify command. `flash_we_o` and `flash_oe_o` are never high together.
- R6: The pulse count restarts at zero for every byte. A byte that first reads correctly after k pulses (k ≤ `MAX_PULSES`) receives exactly k pulses.
- R7: When a byte still mismatches after its `MAX_PULSES`-th pulse, the run fails. `err_o` is high with `err_addr_o` equal to that address, no later address is pulsed, and no read command is written.
- R8: Addresses are programmed in ascending order from `start_addr_i` to `end_addr_i` inclusive. `src_addr_o` steps by exactly one between bytes. A range with start equal to end programs one byte.
- R9: After the last byte verifies, data 00h is written once, while `vpp_req_o` is still high.
- R10: `vpp_req_o` falls at the end of a run (success or failure). `done_o` pulses for exactly one cycle, `RAMP_CYC` cycles after the first cycle with the request low. `err_o` rises only together with `done_o` and stays until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a programming run (idle only) |
| start_addr_i | input | ADDR_W | First address of the range |
| end_addr_i | input | ADDR_W | Last address of the range |
| src_addr_o | output | ADDR_W | Source buffer index (current address) |
| src_data_i | input | DATA_W | Expected byte for `src_addr_o` |
| flash_addr_o | output | ADDR_W | Flash bus address |
| flash_wdata_o | output | DATA_W | Flash bus write data / command |
| flash_rdata_i | input | DATA_W | Flash bus read data |
| flash_we_o | output | 1 | Write strobe, one cycle per command |
| flash_oe_o | output | 1 | Read strobe |
| vpp_req_o | output | 1 | Request for high programming voltage |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run failed |
| err_addr_o | output | ADDR_W | Address that failed |

## Verification
The checker watches several rules on every cycle. The read and write strobes never overlap, and writes happen only under the voltage request. The buffer index only ever advances by one during a run. The completion pulse lasts one cycle with the request low, and the error flag appears only with completion. Other behaviour is visible only in the bench scenarios, which use a flash model whose bytes need a chosen number of pulses. Those scenarios cover the exact ramp, pulse and verify spacings, the per-byte pulse counts, the 25-pulse boundary against the first failing count, the read command on success only, and the ignored start during a run.

// File: rtl/qp_seq_pkg.sv
package qp_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RAMP_UP, S_SETUP, S_PGM, S_PGM_WAIT, S_VFY, S_VFY_WAIT,
    S_READ, S_RDCMD, S_RAMP_DN, S_FIN
  } seq_state_e;

  localparam logic [7:0] CMD_SETUP  = 8'h40;
  localparam logic [7:0] CMD_VERIFY = 8'hC0;
  localparam logic [7:0] CMD_READ   = 8'h00;
endpackage

// File: rtl/qp_delay.sv
module qp_delay #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/qp_pulse_cnt.sv
module qp_pulse_cnt #(
  parameter int MAX_PULSES = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_PULSES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // pulse just verified is the final one allowed
  assign last_o = (cnt_q == CW'(MAX_PULSES - 1));
endmodule

// File: rtl/qp_addr_step.sv
module qp_addr_step #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          inc_i,
  input  logic [AW-1:0] end_addr_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      end_q  <= '0;
    end else if (load_i) begin
      addr_q <= load_addr_i;
      end_q  <= end_addr_i;
    end else if (inc_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o   = addr_q;
  assign at_end_o = (addr_q == end_q);
endmodule

// File: rtl/qp_prog_seq.sv
module qp_prog_seq
  import qp_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAMP_CYC   = 1000,
  parameter int PGM_CYC    = 500,
  parameter int VFY_CYC    = 300,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_wdata_o,
  input  logic [DATA_W-1:0] flash_rdata_i,
  output logic              flash_we_o,
  output logic              flash_oe_o,
  output logic              vpp_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  localparam int TMAX0 = (RAMP_CYC > PGM_CYC) ? RAMP_CYC : PGM_CYC;
  localparam int TMAX  = (TMAX0 > VFY_CYC) ? TMAX0 : VFY_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  seq_state_e state_q, state_d;
  logic tmr_zero, tmr_load;
  logic [TW-1:0] tmr_val;
  logic pc_clr, pc_inc, pc_last;
  logic ad_load, ad_inc, ad_end;
  logic [ADDR_W-1:0] cur_addr;
  logic fail_q, fail_set;
  logic [ADDR_W-1:0] fail_addr_q;
  logic match;

  assign match = (flash_rdata_i == src_data_i);

  always_comb begin
    state_d  = state_q;
    pc_clr   = 1'b0;
    pc_inc   = 1'b0;
    ad_load  = 1'b0;
    ad_inc   = 1'b0;
    fail_set = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_RAMP_UP;
        ad_load = 1'b1;
        pc_clr  = 1'b1;
      end
      S_RAMP_UP:  if (tmr_zero) state_d = S_SETUP;
      S_SETUP:    state_d = S_PGM;
      S_PGM:      state_d = S_PGM_WAIT;
      S_PGM_WAIT: if (tmr_zero) state_d = S_VFY;
      S_VFY:      state_d = S_VFY_WAIT;
      S_VFY_WAIT: if (tmr_zero) state_d = S_READ;
      S_READ: begin
        if (match) begin
          if (ad_end) state_d = S_RDCMD;
          else begin
            state_d = S_SETUP;
            ad_inc  = 1'b1;
            pc_clr  = 1'b1;
          end
        end else if (pc_last) begin
          state_d  = S_RAMP_DN;
          fail_set = 1'b1;
        end else begin
          state_d = S_SETUP;
          pc_inc  = 1'b1;
        end
      end
      S_RDCMD:   state_d = S_RAMP_DN;
      S_RAMP_DN: if (tmr_zero) state_d = S_FIN;
      S_FIN:     state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  // load the shared delay counter on entry to any timed state
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      S_RAMP_UP, S_RAMP_DN: tmr_val = TW'(RAMP_CYC - 1);
      S_PGM_WAIT:           tmr_val = TW'(PGM_CYC - 1);
      S_VFY_WAIT:           tmr_val = TW'(VFY_CYC - 1);
      default: begin
        tmr_val  = '0;
        tmr_load = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (ad_load) fail_q <= 1'b0;
      else if (fail_set) begin
        fail_q      <= 1'b1;
        fail_addr_q <= cur_addr;
      end
    end
  end

  qp_delay #(.W(TW)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  qp_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pc_clr),
    .inc_i(pc_inc), .last_o(pc_last)
  );

  qp_addr_step #(.AW(ADDR_W)) u_astep (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ad_load),
    .load_addr_i(start_addr_i), .inc_i(ad_inc), .end_addr_i(end_addr_i),
    .addr_o(cur_addr), .at_end_o(ad_end)
  );

  always_comb begin
    unique case (state_q)
      S_SETUP: flash_wdata_o = DATA_W'(CMD_SETUP);
      S_PGM:   flash_wdata_o = src_data_i;
      S_VFY:   flash_wdata_o = DATA_W'(CMD_VERIFY);
      default: flash_wdata_o = DATA_W'(CMD_READ);
    endcase
  end

  assign flash_we_o   = (state_q == S_SETUP) || (state_q == S_PGM) ||
                        (state_q == S_VFY)   || (state_q == S_RDCMD);
  assign flash_oe_o   = (state_q == S_READ);
  assign flash_addr_o = cur_addr;
  assign src_addr_o   = cur_addr;
  assign vpp_req_o    = !(state_q inside {S_IDLE, S_RAMP_DN, S_FIN});
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_FIN);
  assign err_o        = fail_q && (state_q inside {S_FIN, S_IDLE});
  assign err_addr_o   = fail_addr_q;
endmodule

// File: rtl/qp_prog_seq_chk.sv
module qp_prog_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              vpp_req_o,
  input logic              flash_we_o,
  input logic              flash_oe_o,
  input logic [ADDR_W-1:0] src_addr_o
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_we_o && flash_oe_o));

  // R3
  we_under_vpp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_we_o |-> vpp_req_o);

  // R3
  no_write_at_ramp_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vpp_req_o) |-> !flash_we_o);

  // R8
  addr_step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && src_addr_o != $past(src_addr_o))
      |-> src_addr_o == $past(src_addr_o) + 1'b1);

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_vpp_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !vpp_req_o);

  // R10
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

bind qp_prog_seq qp_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .vpp_req_o(vpp_req_o), .flash_we_o(flash_we_o),
  .flash_oe_o(flash_oe_o), .src_addr_o(src_addr_o)
);

// File: tb/qp_prog_seq_tb.sv
module qp_prog_seq_tb;
  localparam int AW = 8, DW = 8;
  localparam int TR = 5, TP = 4, TV = 3, MAXP = 25;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [AW-1:0] s_addr = '0, e_addr = '0;
  logic [AW-1:0] src_addr, f_addr, err_addr;
  logic [DW-1:0] src_data, f_wdata, f_rdata;
  logic f_we, f_oe, vpp, busy, done, err;

  logic [7:0] data_tab [256];
  logic [7:0] mem      [256];
  int need_tab [256];
  int pulses   [256];

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign src_data = data_tab[src_addr];
  assign f_rdata  = mem[f_addr];

  qp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .RAMP_CYC(TR), .PGM_CYC(TP),
                .VFY_CYC(TV), .MAX_PULSES(MAXP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(s_addr),
    .end_addr_i(e_addr), .src_addr_o(src_addr), .src_data_i(src_data),
    .flash_addr_o(f_addr), .flash_wdata_o(f_wdata), .flash_rdata_i(f_rdata),
    .flash_we_o(f_we), .flash_oe_o(f_oe), .vpp_req_o(vpp), .busy_o(busy),
    .done_o(done), .err_o(err), .err_addr_o(err_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash model, evaluated at the falling edge
  int mode;          // 0 read, 1 setup seen, 2 programmed, 3 verify
  int t_setup, t_pgm, t_vfy, up_cnt, dn_cnt, done_cnt, rdcmd_cnt;
  bit first_wr, vpp_seen;

  task automatic model_clear();
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; pulses[i] = 0; end
    mode = 0; up_cnt = 0; dn_cnt = 0; done_cnt = 0; rdcmd_cnt = 0;
    first_wr = 0; vpp_seen = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (vpp) vpp_seen = 1;
    if (vpp && !first_wr) begin
      if (f_we) begin
        first_wr = 1;
        chk(up_cnt == TR, "R3 ramp-up", up_cnt, TR);
      end else up_cnt++;
    end
    if (done) begin
      done_cnt++;
      chk(dn_cnt == TR, "R10 ramp-down", dn_cnt, TR);
    end else if (!vpp && vpp_seen) dn_cnt++;
    if (f_we && !vpp) chk(0, "R3 write without vpp", 0, 1);
    if (f_oe) begin
      chk(mode == 3 && cyc - t_vfy == TV + 1, "R5 verify spacing", cyc - t_vfy, TV + 1);
    end
    if (f_we) begin
      if (mode == 1) begin
        chk(cyc - t_setup == 1, "R4 data after setup", cyc - t_setup, 1);
        chk(f_wdata == data_tab[f_addr], "R4 data value", f_wdata, data_tab[f_addr]);
        pulses[f_addr]++;
        if (pulses[f_addr] >= need_tab[f_addr]) mem[f_addr] = f_wdata;
        t_pgm = cyc; mode = 2;
      end else if (f_wdata == 8'h40) begin
        t_setup = cyc; mode = 1;
      end else if (f_wdata == 8'hC0) begin
        chk(mode == 2 && cyc - t_pgm == TP + 1, "R4 verify cmd spacing", cyc - t_pgm, TP + 1);
        t_vfy = cyc; mode = 3;
      end else if (f_wdata == 8'h00) begin
        rdcmd_cnt++; mode = 0;
      end
    end
  end

  task automatic fill(input int lo, input int hi, input int nmax);
    for (int i = 0; i < 256; i++) begin
      data_tab[i] = 8'($urandom) & 8'hFE;
      need_tab[i] = 1 + int'($urandom % nmax);
    end
  endtask

  // run a range, optionally poking start while busy, then check outcome
  task automatic run(input int lo, input int hi, input bit stray);
    int fail_at, k;
    model_clear();
    fail_at = -1;
    for (int a = lo; a <= hi; a++)
      if (need_tab[a] > MAXP && fail_at < 0) fail_at = a;
    @(negedge clk);
    s_addr = AW'(lo); e_addr = AW'(hi); start = 1;
    @(negedge clk);
    start = 0;
    k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
      if (stray && k == 30) begin
        chk(busy == 1, "R2 busy during run", busy, 1);
        s_addr = AW'(hi + 3); e_addr = AW'(hi + 5); start = 1;
      end
      if (stray && k == 31) start = 0;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(busy == 0 && vpp == 0, "R10 idle after done", busy, 0);
    chk(err == (fail_at >= 0), "R7 err flag", err, fail_at >= 0);
    if (fail_at >= 0) begin
      chk(err_addr == AW'(fail_at), "R7 err addr", err_addr, fail_at);
      chk(rdcmd_cnt == 0, "R7 no read cmd", rdcmd_cnt, 0);
    end else chk(rdcmd_cnt == 1, "R9 read cmd", rdcmd_cnt, 1);
    for (int a = 0; a < 256; a++) begin
      int exp_p;
      if (a < lo || a > hi || (fail_at >= 0 && a > fail_at)) exp_p = 0;
      else if (need_tab[a] > MAXP) exp_p = MAXP;
      else exp_p = need_tab[a];
      if (pulses[a] != exp_p)
        chk(0, (a < lo || a > hi) ? "R2/R8 out of range pulsed" : "R6 pulse count", pulses[a], exp_p);
      if (exp_p > 0 && need_tab[a] <= MAXP)
        if (mem[a] != data_tab[a]) chk(0, "R8 byte content", mem[a], data_tab[a]);
    end
    n_tests++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, err, vpp, f_we, f_oe} == 6'b0, "R1 reset state",
        {busy, done, err, vpp, f_we, f_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({busy, vpp} == 2'b0, "R1 idle after reset", {busy, vpp}, 0);

    // R8 directed: one pulse per byte
    fill(0, 0, 1); run(10, 12, 0);
    // R6 random patterns
    for (int r = 0; r < 4; r++) begin
      int lo;
      lo = int'($urandom % 40);
      fill(0, 0, 5);
      run(lo, lo + int'($urandom % 6), 0);
    end
    // R6 boundary: exactly MAXP pulses succeeds
    fill(0, 0, 2); need_tab[21] = MAXP; run(20, 22, 0);
    // R7 failure mid-range
    fill(0, 0, 3); need_tab[33] = MAXP + 1; run(31, 36, 0);
    chk(err == 1, "R10 err held while idle", err, 1);
    // R7 failure on first byte
    fill(0, 0, 3); need_tab[50] = 99; run(50, 52, 0);
    // R8 single-byte range, clears err
    fill(0, 0, 4); run(60, 60, 0);
    chk(err == 0, "R10 err cleared by start", err, 0);
    // R2 start during run ignored
    fill(0, 0, 4); run(70, 74, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule